// File: doc/BRIEF.md
# Transactional Memory State Controller

This block keeps the transactional state of a single-thread in-order core. It counts retired transaction-begin instructions and completed transaction-end (commit) accesses, and derives the nesting depth from the two counts. The core is inside a transaction whenever that depth is non-zero. On the outermost begin it draws a fresh transaction identifier. It tags the core's outgoing memory requests with a transactional flag while a transaction runs. It also holds back interrupts until the depth has fallen back to zero.

Failures become abort requests that carry a cause code. A fault raised inside a transaction becomes an abort with cause EXCEPTION. A failure flagged on a load or command response becomes an abort with cause SIZE when the line was evicted by this core, or MEMORY when a remote request conflicted. Failures reported on store responses are dropped. When an abort is issued, the block clears both counters. The abort request itself carries the transactional tag and the current identifier, so the memory side can match it. Conflict detection in the cache and register checkpoint restore belong to other blocks.

Top module: `htm_state_ctrl`

## Requirements
- R1: After reset the depth is 0, the core is not transactional, the identifier is 0, and both abort_o and err_o are 0.
- R2: A begin strobe raises depth_o by one at the next clock edge. An end strobe while the depth is non-zero lowers it by one. A begin and an end in the same cycle leave it unchanged. in_tx_o is 1 exactly when depth_o is non-zero.
- R3: tx_id_o increments by one (wrapping at 2^ID_W) only on a begin accepted at depth 0. Nested begins leave it unchanged.
- R4: irq_take_o equals irq_pending_i while the depth is 0 and is 0 while in a transaction. This holds in the same cycle, with no register.
- R5: req_tag_o is 1 when req_valid_i is high while in a transaction, and also during every cycle in which abort_o is high.
- R6: fault_i while in a transaction, with fault_htm_i low, gives abort_o one cycle later with cause 0 (EXCEPTION). A fault with fault_htm_i high, or any fault outside a transaction, gives no abort.
- R7: A response with rsp_valid_i, rsp_fail_i and not rsp_store_i, while in a transaction, gives abort_o one cycle later. The cause is 1 (SIZE) when rsp_remote_i is 0 and 2 (MEMORY) when it is 1. A qualifying fault in the same cycle takes priority with cause 0. Cause 3 is never issued.
- R8: A failure flagged on a store response (rsp_store_i high) causes no abort and no change of depth.
- R9: The clock edge that raises abort_o also clears the depth to 0. abort_o is a one-cycle pulse. An abort takes priority over a begin or end in the same cycle, and in that case the identifier does not advance.
- R10: err_o pulses for one cycle after any of these: a tagged response whose rsp_id_i differs from tx_id_o, a non-store failure outside a transaction, an end strobe at depth 0, or a begin strobe at maximum depth.
- R11: A begin strobe at maximum depth (2^CNT_W-1) is dropped and the depth stays at the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin_i | input | 1 | Transaction-begin instruction retired |
| tx_end_i | input | 1 | Transaction-end access completed |
| fault_i | input | 1 | Fault raised by the current instruction |
| fault_htm_i | input | 1 | The fault is already a transactional failure |
| rsp_valid_i | input | 1 | Memory response valid |
| rsp_store_i | input | 1 | Response belongs to a store |
| rsp_fail_i | input | 1 | Cache flagged a transactional failure |
| rsp_remote_i | input | 1 | Failure caused by a remote request (0 = own eviction) |
| rsp_tagged_i | input | 1 | Response carries a transaction identifier |
| rsp_id_i | input | ID_W | Identifier carried by the response |
| req_valid_i | input | 1 | Core issues a memory request this cycle |
| irq_pending_i | input | 1 | An interrupt is pending |
| in_tx_o | output | 1 | Core is in transactional state |
| depth_o | output | CNT_W | Nesting depth |
| tx_id_o | output | ID_W | Current transaction identifier |
| req_tag_o | output | 1 | Mark the outgoing request or abort as transactional |
| irq_take_o | output | 1 | Pending interrupt may be taken |
| abort_o | output | 1 | Abort request pulse |
| abort_cause_o | output | 2 | Abort cause: 0 exception, 1 size, 2 memory |
| err_o | output | 1 | Consistency error pulse |

## Verification
irq_take_o and req_tag_o are combinational, so the bench samples them shortly after it drives the inputs and before the next rising edge. depth_o, in_tx_o, tx_id_o, abort_o, abort_cause_o and err_o each sit behind one register. They are checked just after the rising edge that follows the stimulus, against a cycle model in the bench that is stepped at that same edge. The directed cases are placed so that each lands in that one-cycle window: the store failure, the begin at maximum depth, the simultaneous abort and begin, and the identifier mismatch.

// File: rtl/htm_pkg.sv
package htm_pkg;
  typedef enum logic [1:0] {
    CAUSE_EXCEPTION = 2'd0,
    CAUSE_SIZE      = 2'd1,
    CAUSE_MEMORY    = 2'd2,
    CAUSE_RSVD      = 2'd3
  } htm_cause_e;
endpackage

// File: rtl/htm_nest_ctr.sv
module htm_nest_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             begin_i,
  input  logic             end_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] depth_o,
  output logic             active_o,
  output logic             outer_begin_o,
  output logic             begin_drop_o,
  output logic             end_drop_o
);
  localparam logic [CNT_W-1:0] DEPTH_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] begins_q, begins_d;
  logic [CNT_W-1:0] ends_q, ends_d;
  logic [CNT_W-1:0] depth_d;
  logic             full, take_b, take_e, cnt_en;

  assign depth_o  = begins_q - ends_q;
  assign active_o = (depth_o != '0);
  assign full     = (depth_o == DEPTH_MAX);

  always_comb begin
    take_b        = begin_i & ~full & ~clear_i;
    take_e        = end_i & active_o & ~clear_i;
    outer_begin_o = take_b & ~active_o;
    begin_drop_o  = begin_i & full & ~clear_i;
    end_drop_o    = end_i & ~active_o & ~clear_i;
    cnt_en        = clear_i | take_b | take_e;
    begins_d      = begins_q + CNT_W'(take_b);
    ends_d        = ends_q + CNT_W'(take_e);
    depth_d       = begins_d - ends_d;
    if (clear_i || depth_d == '0) begin
      begins_d = '0;
      ends_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      begins_q <= '0;
      ends_q   <= '0;
    end else if (cnt_en) begin
      begins_q <= begins_d;
      ends_q   <= ends_d;
    end
  end

  // R2: a lone accepted begin deepens nesting by exactly one
  assert_depth_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && !end_i && !clear_i && !full) |=> (depth_o == $past(depth_o) + CNT_W'(1)));
  // R11: a begin at full depth is dropped
  assert_full_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && !end_i && !clear_i && full) |=> (depth_o == DEPTH_MAX));
endmodule

// File: rtl/htm_txid.sv
module htm_txid #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  output logic [ID_W-1:0] id_o
);
  logic [ID_W-1:0] id_q, id_d;

  always_comb id_d = id_q + ID_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (adv_i) id_q <= id_d;
  end

  assign id_o = id_q;

  // R3: identifier only moves when an outermost begin is accepted
  assert_id_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(id_o));
endmodule

// File: rtl/htm_abort_map.sv
module htm_abort_map
  import htm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_tx_i,
  input  logic       fault_i,
  input  logic       fault_htm_i,
  input  logic       rsp_valid_i,
  input  logic       rsp_store_i,
  input  logic       rsp_fail_i,
  input  logic       rsp_remote_i,
  output logic       abort_now_o,
  output logic       fail_idle_o,
  output logic       abort_o,
  output htm_cause_e cause_o
);
  logic       fault_hit, mem_fail, mem_hit;
  htm_cause_e cause_d;
  logic       abort_q;
  htm_cause_e cause_q;

  always_comb begin
    fault_hit   = fault_i & ~fault_htm_i & in_tx_i;
    mem_fail    = rsp_valid_i & rsp_fail_i & ~rsp_store_i;
    mem_hit     = mem_fail & in_tx_i;
    abort_now_o = fault_hit | mem_hit;
    fail_idle_o = mem_fail & ~in_tx_i;
    if (fault_hit)         cause_d = CAUSE_EXCEPTION;
    else if (rsp_remote_i) cause_d = CAUSE_MEMORY;
    else                   cause_d = CAUSE_SIZE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= abort_now_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cause_q <= CAUSE_EXCEPTION;
    else if (abort_now_o) cause_q <= cause_d;
  end

  assign abort_o = abort_q;
  assign cause_o = cause_q;

  // R7: reserved cause never leaves the block
  assert_cause_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (cause_o != CAUSE_RSVD));
  // R8: a failing store response alone never aborts
  assert_store_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_i && rsp_store_i && !fault_i) |=> !abort_o);
endmodule

// File: rtl/htm_state_ctrl.sv
module htm_state_ctrl
  import htm_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_begin_i,
  input  logic             tx_end_i,
  input  logic             fault_i,
  input  logic             fault_htm_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_store_i,
  input  logic             rsp_fail_i,
  input  logic             rsp_remote_i,
  input  logic             rsp_tagged_i,
  input  logic [ID_W-1:0]  rsp_id_i,
  input  logic             req_valid_i,
  input  logic             irq_pending_i,
  output logic             in_tx_o,
  output logic [CNT_W-1:0] depth_o,
  output logic [ID_W-1:0]  tx_id_o,
  output logic             req_tag_o,
  output logic             irq_take_o,
  output logic             abort_o,
  output logic [1:0]       abort_cause_o,
  output logic             err_o
);
  logic       abort_now, fail_idle;
  logic       outer_begin, begin_drop, end_drop;
  logic       id_mismatch, err_d, err_q;
  htm_cause_e cause;

  htm_abort_map u_abort (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_tx_i     (in_tx_o),
    .fault_i     (fault_i),
    .fault_htm_i (fault_htm_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_store_i (rsp_store_i),
    .rsp_fail_i  (rsp_fail_i),
    .rsp_remote_i(rsp_remote_i),
    .abort_now_o (abort_now),
    .fail_idle_o (fail_idle),
    .abort_o     (abort_o),
    .cause_o     (cause)
  );

  htm_nest_ctr #(.CNT_W(CNT_W)) u_nest (
    .clk          (clk),
    .rst_n        (rst_n),
    .begin_i      (tx_begin_i),
    .end_i        (tx_end_i),
    .clear_i      (abort_now),
    .depth_o      (depth_o),
    .active_o     (in_tx_o),
    .outer_begin_o(outer_begin),
    .begin_drop_o (begin_drop),
    .end_drop_o   (end_drop)
  );

  htm_txid #(.ID_W(ID_W)) u_id (
    .clk  (clk),
    .rst_n(rst_n),
    .adv_i(outer_begin),
    .id_o (tx_id_o)
  );

  always_comb begin
    id_mismatch = rsp_valid_i & rsp_tagged_i & (rsp_id_i != tx_id_o);
    err_d       = id_mismatch | fail_idle | begin_drop | end_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o         = err_q;
  assign abort_cause_o = cause;
  assign irq_take_o    = irq_pending_i & ~in_tx_o;
  assign req_tag_o     = (req_valid_i & in_tx_o) | abort_o;

  // R9: the abort pulse coincides with cleared nesting
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (depth_o == '0));
  // R9: abort is a single-cycle pulse
  assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  // R4: no interrupt taken inside a transaction
  assert_irq_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o != '0) |-> !irq_take_o);
endmodule

// File: tb/test_htm_state_ctrl.sv
`timescale 1ns/1ps
module test_htm_state_ctrl;
  localparam int ID_W  = 64;
  localparam int CNT_W = 4;
  localparam int DMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_begin_i, tx_end_i, fault_i, fault_htm_i;
  logic rsp_valid_i, rsp_store_i, rsp_fail_i, rsp_remote_i, rsp_tagged_i;
  logic [ID_W-1:0] rsp_id_i;
  logic req_valid_i, irq_pending_i;
  logic in_tx_o, req_tag_o, irq_take_o, abort_o, err_o;
  logic [CNT_W-1:0] depth_o;
  logic [ID_W-1:0] tx_id_o;
  logic [1:0] abort_cause_o;

  always #10 clk = ~clk;

  htm_state_ctrl #(.ID_W(ID_W), .CNT_W(CNT_W)) i_htm_state_ctrl (
    .clk(clk), .rst_n(rst_n),
    .tx_begin_i(tx_begin_i), .tx_end_i(tx_end_i),
    .fault_i(fault_i), .fault_htm_i(fault_htm_i),
    .rsp_valid_i(rsp_valid_i), .rsp_store_i(rsp_store_i),
    .rsp_fail_i(rsp_fail_i), .rsp_remote_i(rsp_remote_i),
    .rsp_tagged_i(rsp_tagged_i), .rsp_id_i(rsp_id_i),
    .req_valid_i(req_valid_i), .irq_pending_i(irq_pending_i),
    .in_tx_o(in_tx_o), .depth_o(depth_o), .tx_id_o(tx_id_o),
    .req_tag_o(req_tag_o), .irq_take_o(irq_take_o),
    .abort_o(abort_o), .abort_cause_o(abort_cause_o), .err_o(err_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          m_depth;
  logic [63:0] m_id;
  bit          m_abort, m_err;
  int          m_cause;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_begin_i = 0; tx_end_i = 0; fault_i = 0; fault_htm_i = 0;
    rsp_valid_i = 0; rsp_store_i = 0; rsp_fail_i = 0; rsp_remote_i = 0;
    rsp_tagged_i = 0; rsp_id_i = '0; req_valid_i = 0; irq_pending_i = 0;
  endtask

  // model of one clock edge, from the requirements
  task automatic model_edge();
    bit intx, fhit, mfail, ab, b, e, mism;
    int nd;
    intx  = (m_depth != 0);
    fhit  = fault_i && !fault_htm_i && intx;
    mfail = rsp_valid_i && rsp_fail_i && !rsp_store_i;
    ab    = fhit || (mfail && intx);
    mism  = rsp_valid_i && rsp_tagged_i && (rsp_id_i != m_id);
    m_err = mism || (mfail && !intx) ||
            (!ab && tx_begin_i && m_depth == DMAX) || (!ab && tx_end_i && !intx);
    if (ab) begin
      m_cause = fhit ? 0 : (rsp_remote_i ? 2 : 1);
      m_depth = 0;
    end else begin
      b  = tx_begin_i && m_depth != DMAX;
      e  = tx_end_i && intx;
      nd = m_depth + int'(b) - int'(e);
      if (b && m_depth == 0) m_id = m_id + 64'd1;
      m_depth = nd;
    end
    m_abort = ab;
  endtask

  // inputs are set just after a falling edge; this task checks and advances
  task automatic step();
    #2;
    chk(irq_take_o == (irq_pending_i && m_depth == 0), "R4 irq_take", irq_take_o, irq_pending_i && m_depth == 0);
    chk(req_tag_o == ((req_valid_i && m_depth != 0) || m_abort), "R5 req_tag", req_tag_o,
        (req_valid_i && m_depth != 0) || m_abort);
    model_edge();
    @(posedge clk); #2;
    chk(depth_o == CNT_W'(m_depth), "R2 R9 R11 depth", depth_o, m_depth);
    chk(in_tx_o == (m_depth != 0), "R2 in_tx", in_tx_o, m_depth != 0);
    chk(tx_id_o == m_id, "R3 tx_id", tx_id_o, m_id);
    chk(abort_o == m_abort, "R6 R7 R8 R9 abort", abort_o, m_abort);
    if (m_abort) chk(abort_cause_o == 2'(m_cause), "R6 R7 cause", abort_cause_o, m_cause);
    chk(err_o == m_err, "R10 err", err_o, m_err);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    idle_inputs();
    rst_n = 1'b0;
    m_depth = 0; m_id = '0; m_abort = 0; m_err = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(depth_o == '0 && !in_tx_o, "R1 depth", depth_o, 0);
    chk(tx_id_o == '0, "R1 tx_id", tx_id_o, 0);
    chk(!abort_o && !err_o, "R1 abort/err", {abort_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 nested begins: only the first draws an identifier
    tx_begin_i = 1; step();
    tx_begin_i = 1; step();
    chk(tx_id_o == 64'd1, "R3 nested id", tx_id_o, 1);
    // R4 interrupt held inside the transaction
    irq_pending_i = 1; step();
    // R8 store failure ignored
    rsp_valid_i = 1; rsp_store_i = 1; rsp_fail_i = 1; step();
    chk(depth_o == 2 && !abort_o, "R8 store fail ignored", depth_o, 2);
    // R7 own eviction -> size
    rsp_valid_i = 1; rsp_fail_i = 1; rsp_remote_i = 0; step();
    chk(abort_o && abort_cause_o == 2'd1, "R7 size cause", abort_cause_o, 1);
    step();
    // R9 abort wins over a begin in the same cycle
    tx_begin_i = 1; step();
    tx_begin_i = 1; rsp_valid_i = 1; rsp_fail_i = 1; rsp_remote_i = 1; step();
    chk(depth_o == 0 && abort_cause_o == 2'd2, "R9 abort beats begin", depth_o, 0);
    // R6 fault with priority over memory failure
    tx_begin_i = 1; step();
    fault_i = 1; rsp_valid_i = 1; rsp_fail_i = 1; rsp_remote_i = 1; step();
    chk(abort_cause_o == 2'd0, "R6 exception priority", abort_cause_o, 0);
    // R6 fault outside a transaction: no abort
    fault_i = 1; step();
    // R10 end at depth 0, failure outside transaction, id mismatch
    tx_end_i = 1; step();
    rsp_valid_i = 1; rsp_fail_i = 1; step();
    rsp_valid_i = 1; rsp_tagged_i = 1; rsp_id_i = m_id ^ 64'h80; step();
    // R11 fill to the maximum depth and overflow by one
    for (int k = 0; k < DMAX + 1; k++) begin
      tx_begin_i = 1; step();
    end
    chk(depth_o == CNT_W'(DMAX) && err_o, "R11 begin at max dropped", depth_o, DMAX);
    for (int k = 0; k < DMAX; k++) begin
      tx_end_i = 1; step();
    end

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      tx_begin_i    = ($urandom % 100) < 30;
      tx_end_i      = ($urandom % 100) < 25;
      fault_i       = ($urandom % 100) < 3;
      fault_htm_i   = $urandom % 2;
      rsp_valid_i   = ($urandom % 100) < 30;
      rsp_store_i   = $urandom % 2;
      rsp_fail_i    = ($urandom % 100) < 8;
      rsp_remote_i  = $urandom % 2;
      rsp_tagged_i  = $urandom % 2;
      rsp_id_i      = (($urandom % 10) == 0) ? {32'($urandom), 32'($urandom)} : m_id;
      req_valid_i   = $urandom % 2;
      irq_pending_i = $urandom % 2;
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule